// File: doc/BRIEF.md
# Integer Execution Unit with Tagged Arithmetic and Multiply-Step

This block is the integer execution stage of a load/store RISC core. Each cycle it can accept one operation. The operation carries a first operand from the register file, a second register operand, and a 22-bit instruction field. Bit 13 of that field chooses whether the second operand is the register value or a sign-extended 13-bit immediate. For the upper-immediate operation, the whole field is the constant.

The unit performs add, subtract, four logical operations, tagged add and subtract, a trapping form of the tagged operations, one multiply-step iteration, and an upper-immediate build. It also has an operation that loads the auxiliary multiplier register. Each result is registered one cycle after the request. The negative, zero, overflow and carry flags are architectural state held here, and so is the multiplier register. Both are visible at the ports after every operation.

A multiplication is run as a chain of multiply-step operations issued back to back. Each step sees the flags and the multiplier register written by the step before it.

Top module: `iexec_unit`

## Requirements
- R1: When `in_field[13]` is 1, the second operand is `in_field[12:0]` sign-extended to 32 bits, so the range is -4096 to +4095. When `in_field[13]` is 0, the second operand is `in_rs2`.
- R2: Add (op 0) gives rs1+op2 and subtract (op 1) gives rs1-op2. With `in_set_cc`=1, the flags are written as {N,Z,V,C} on `out_flags[3:0]`. N is the result MSB, Z is set when the result is zero, and V is signed overflow. C is the carry out for add and the borrow for subtract.
- R3: The logical ops are AND (op 2), OR (op 3), XOR (op 4) and AND-NOT (op 5, rs1 & ~op2). With `in_set_cc`=1, N and Z come from the result and V and C are cleared.
- R4: An operation with `in_set_cc`=0 leaves `out_flags` unchanged, except multiply-step. A cycle without `in_valid` changes neither the flags nor `out_y`.
- R5: Tagged add (op 6) and tagged subtract (op 7) produce the add or subtract result. V is also set when bits 1:0 of either operand are nonzero.
- R6: The trapping tagged add (op 8) and trapping tagged subtract (op 9) raise `out_trap` when V would be set. When they trap, `out_wr`=0, `out_data`=0, and the flags are not written. When they do not trap, they behave as op 6 and op 7.
- R7: Upper immediate (op 11) returns `{in_field, 10'b0}` with `out_wr`=1 and does not touch the flags.
- R8: Multiply-step (op 10) always writes the flags. If `out_y[0]` is 1 it adds op2, otherwise it adds zero. The addend goes to `{N xor V, rs1[31:1]}`, and the flags are taken from that add. Y becomes `{rs1[0], Y[31:1]}`.
- R9: Load-Y (op 12) sets Y to rs1 xor op2, with `out_wr`=0, `out_data`=0 and the flags unchanged.
- R10: `out_valid` follows `in_valid` by one clock, and the result, flags and Y change on that same edge. A synchronous reset clears every output, the flags and Y.
- R11: Op codes 13 to 15 produce `out_valid` with `out_wr`=0, `out_data`=0 and `out_trap`=0, and leave the flags and Y unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| in_op | input | 4 | Operation code |
| in_set_cc | input | 1 | Write the flags with this operation |
| in_field | input | 22 | Instruction field: bit 13 selects the operand, bits 12:0 are the immediate, all bits feed the upper-immediate op |
| in_rs1 | input | 32 | First register operand |
| in_rs2 | input | 32 | Second register operand |
| out_valid | output | 1 | Result of the previous cycle's request |
| out_data | output | 32 | Result value |
| out_wr | output | 1 | Result is to be written to the destination |
| out_trap | output | 1 | Tag-overflow trap |
| out_flags | output | 4 | Flags {N,Z,V,C} |
| out_y | output | 32 | Multiplier register |

## Verification
A wrong flag bit or a wrong Y value is visible on `out_flags` and `out_y` in the cycle after the operation that wrote it. The effect is easy to miss when it appears only in later results. A stale N xor V, or a Y that shifted the wrong way, only shows as a wrong partial product one multiply-step later. For that reason the bench chains steps back to back and compares the flags and Y after every operation, not only the result. A trap that leaked a flag write is caught at once by comparing the flags with their value before the trapping operation.

// File: rtl/iexec_pkg.sv
package iexec_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_XOR   = 4'd4,
    OP_ANDN  = 4'd5,
    OP_TADD  = 4'd6,
    OP_TSUB  = 4'd7,
    OP_TADDT = 4'd8,
    OP_TSUBT = 4'd9,
    OP_MSTEP = 4'd10,
    OP_SETHI = 4'd11,
    OP_WRY   = 4'd12
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/iexec_opsel.sv
module iexec_opsel #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 13
) (
  input  logic [IMM_W:0]    sel_imm,
  input  logic [XLEN-1:0]   rs2,
  output logic [XLEN-1:0]   op2
);
  localparam int EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] imm_ext;

  // R1: sign-extend the short immediate; the bit above it selects the source
  assign imm_ext = {{EXT_W{sel_imm[IMM_W-1]}}, sel_imm[IMM_W-1:0]};
  assign op2     = sel_imm[IMM_W] ? imm_ext : rs2;
endmodule

// File: rtl/iexec_core.sv
module iexec_core
  import iexec_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int HI_W  = 22,
  parameter int TAG_W = 2
) (
  input  op_e              op,
  input  logic             set_cc,
  input  logic [XLEN-1:0]  op1,
  input  logic [XLEN-1:0]  op2,
  input  logic [HI_W-1:0]  hi_imm,
  input  flags_t           flg,
  input  logic [XLEN-1:0]  y,
  output logic [XLEN-1:0]  res,
  output logic             res_wr,
  output logic             flg_wr,
  output flags_t           flg_nxt,
  output logic             y_wr,
  output logic [XLEN-1:0]  y_nxt,
  output logic             trap
);
  localparam int LO_W = XLEN - HI_W;

  logic            is_sub, is_tag, is_trapv, is_mstep;
  logic [XLEN-1:0] add_a, add_b, logic_r;
  logic [XLEN:0]   sum;
  logic            ovf_s, tag_bad, v_all;

  // Shared adder: add, subtract, tagged forms and the multiply-step
  always_comb begin
    is_sub   = (op == OP_SUB) || (op == OP_TSUB) || (op == OP_TSUBT);
    is_tag   = (op == OP_TADD) || (op == OP_TSUB) || (op == OP_TADDT) || (op == OP_TSUBT);
    is_trapv = (op == OP_TADDT) || (op == OP_TSUBT);
    is_mstep = (op == OP_MSTEP);
    add_a    = is_mstep ? {flg.n ^ flg.v, op1[XLEN-1:1]} : op1;
    if (is_mstep)    add_b = y[0] ? op2 : '0;
    else if (is_sub) add_b = ~op2;
    else             add_b = op2;
    sum      = {1'b0, add_a} + {1'b0, add_b} + {{XLEN{1'b0}}, is_sub};
    ovf_s    = (add_a[XLEN-1] == add_b[XLEN-1]) && (sum[XLEN-1] != add_a[XLEN-1]);
    tag_bad  = is_tag && ((|op1[TAG_W-1:0]) || (|op2[TAG_W-1:0]));
    v_all    = ovf_s | tag_bad;
  end

  always_comb begin
    case (op)
      OP_AND:  logic_r = op1 & op2;
      OP_OR:   logic_r = op1 | op2;
      OP_XOR:  logic_r = op1 ^ op2;
      default: logic_r = op1 & ~op2;
    endcase
  end

  always_comb begin
    res     = '0;
    res_wr  = 1'b0;
    flg_wr  = 1'b0;
    flg_nxt = flg;
    y_wr    = 1'b0;
    y_nxt   = y;
    trap    = 1'b0;
    case (op)
      OP_ADD, OP_SUB, OP_TADD, OP_TSUB, OP_TADDT, OP_TSUBT, OP_MSTEP: begin
        res       = sum[XLEN-1:0];
        res_wr    = 1'b1;
        flg_nxt.n = sum[XLEN-1];
        flg_nxt.z = (sum[XLEN-1:0] == '0);
        flg_nxt.v = v_all;
        flg_nxt.c = sum[XLEN] ^ is_sub;
        flg_wr    = set_cc | is_mstep;
        if (is_trapv && v_all) begin
          trap   = 1'b1;
          res    = '0;
          res_wr = 1'b0;
          flg_wr = 1'b0;
        end
        if (is_mstep) begin
          y_wr  = 1'b1;
          y_nxt = {op1[0], y[XLEN-1:1]};
        end
      end
      OP_AND, OP_OR, OP_XOR, OP_ANDN: begin
        res       = logic_r;
        res_wr    = 1'b1;
        flg_nxt.n = logic_r[XLEN-1];
        flg_nxt.z = (logic_r == '0);
        flg_nxt.v = 1'b0;
        flg_nxt.c = 1'b0;
        flg_wr    = set_cc;
      end
      OP_SETHI: begin
        res    = {hi_imm, {LO_W{1'b0}}};
        res_wr = 1'b1;
      end
      OP_WRY: begin
        y_wr  = 1'b1;
        y_nxt = op1 ^ op2;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/iexec_unit.sv
module iexec_unit
  import iexec_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 13,
  parameter int HI_W  = 22,
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [3:0]       in_op,
  input  logic             in_set_cc,
  input  logic [HI_W-1:0]  in_field,
  input  logic [XLEN-1:0]  in_rs1,
  input  logic [XLEN-1:0]  in_rs2,
  output logic             out_valid,
  output logic [XLEN-1:0]  out_data,
  output logic             out_wr,
  output logic             out_trap,
  output logic [3:0]       out_flags,
  output logic [XLEN-1:0]  out_y
);
  localparam int LO_W = XLEN - HI_W;

  op_e             op;
  logic [XLEN-1:0] op2;
  logic [XLEN-1:0] c_res, c_ynxt;
  logic            c_reswr, c_flgwr, c_ywr, c_trap;
  flags_t          c_flgnxt;
  flags_t          flags_q;

  assign op = op_e'(in_op);

  iexec_opsel #(.XLEN(XLEN), .IMM_W(IMM_W)) u_opsel (
    .sel_imm (in_field[IMM_W:0]),
    .rs2     (in_rs2),
    .op2     (op2)
  );

  iexec_core #(.XLEN(XLEN), .HI_W(HI_W), .TAG_W(TAG_W)) u_core (
    .op      (op),
    .set_cc  (in_set_cc),
    .op1     (in_rs1),
    .op2     (op2),
    .hi_imm  (in_field),
    .flg     (flags_q),
    .y       (out_y),
    .res     (c_res),
    .res_wr  (c_reswr),
    .flg_wr  (c_flgwr),
    .flg_nxt (c_flgnxt),
    .y_wr    (c_ywr),
    .y_nxt   (c_ynxt),
    .trap    (c_trap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_wr    <= 1'b0;
      out_trap  <= 1'b0;
      flags_q   <= '0;
      out_y     <= '0;
    end else begin
      out_valid <= in_valid;
      out_data  <= in_valid ? c_res : '0;
      out_wr    <= in_valid & c_reswr;
      out_trap  <= in_valid & c_trap;
      if (in_valid && c_flgwr) flags_q <= c_flgnxt;
      if (in_valid && c_ywr)   out_y   <= c_ynxt;
    end
  end

  assign out_flags = flags_q;

  // Checks on the registered state
  p_latency_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_quiet_keeps_state_r4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_flags) && $stable(out_y)));
  p_logic_clears_vc_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_set_cc && (in_op == OP_AND || in_op == OP_OR ||
                               in_op == OP_XOR || in_op == OP_ANDN))
    |=> (out_flags[1:0] == 2'b00));
  p_sethi_low_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_SETHI) |=> (out_wr && out_data[LO_W-1:0] == '0));
  p_trap_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    out_trap |-> (!out_wr && out_data == '0));
  p_trap_keeps_flags_r6: assert property (@(posedge clk) disable iff (rst)
    out_trap |-> (out_flags == $past(out_flags)));
  p_mstep_y_shift_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_MSTEP) |=>
    (out_y[XLEN-2:0] == $past(out_y[XLEN-1:1]) && out_y[XLEN-1] == $past(in_rs1[0])));
endmodule

// File: tb/iexec_unit_tb.sv
module iexec_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  in_op;
  logic        in_set_cc;
  logic [21:0] in_field;
  logic [31:0] in_rs1, in_rs2;
  logic        out_valid, out_wr, out_trap;
  logic [31:0] out_data, out_y;
  logic [3:0]  out_flags;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [31:0] data;
    logic        wr;
    logic        trap;
    logic [3:0]  flags;
    logic [31:0] y;
  } exp_t;

  exp_t  eq[$];
  string tq[$];

  logic [3:0]  m_flags = 4'h0;
  logic [31:0] m_y     = 32'h0;
  logic [31:0] last_res = 32'h0;

  always #4 clk = ~clk;

  iexec_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_set_cc(in_set_cc), .in_field(in_field), .in_rs1(in_rs1),
    .in_rs2(in_rs2), .out_valid(out_valid), .out_data(out_data),
    .out_wr(out_wr), .out_trap(out_trap), .out_flags(out_flags),
    .out_y(out_y)
  );

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:                 return "R2";
      4'd2, 4'd3, 4'd4, 4'd5:     return "R3";
      4'd6, 4'd7:                 return "R5";
      4'd8, 4'd9:                 return "R6";
      4'd10:                      return "R8";
      4'd11:                      return "R7";
      4'd12:                      return "R9";
      default:                    return "R11";
    endcase
  endfunction

  // Driver: builds the expected item from the requirements and applies the op
  task automatic issue(input logic [3:0] op, input logic cc, input logic [21:0] fld,
                       input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [31:0] o2, r, sh, ad;
    logic [32:0] r33;
    logic        v, c, sub, trp;
    exp_t        e;
    o2  = fld[13] ? {{19{fld[12]}}, fld[12:0]} : b;
    e   = '0;
    trp = 1'b0;
    case (op)
      4'd0, 4'd1, 4'd6, 4'd7, 4'd8, 4'd9: begin
        sub = (op == 4'd1) || (op == 4'd7) || (op == 4'd9);
        r33 = sub ? ({1'b0, a} - {1'b0, o2}) : ({1'b0, a} + {1'b0, o2});
        r   = r33[31:0];
        c   = r33[32];
        v   = sub ? ((a[31] != o2[31]) && (r[31] != a[31]))
                  : ((a[31] == o2[31]) && (r[31] != a[31]));
        if (op >= 4'd6) v = v || (a[1:0] != 2'b00) || (o2[1:0] != 2'b00);
        trp = (op == 4'd8 || op == 4'd9) && v;
        if (trp) begin
          e.trap = 1'b1;
        end else begin
          e.data = r; e.wr = 1'b1;
          if (cc) m_flags = {r[31], r == 32'h0, v, c};
        end
      end
      4'd2, 4'd3, 4'd4, 4'd5: begin
        case (op)
          4'd2:    r = a & o2;
          4'd3:    r = a | o2;
          4'd4:    r = a ^ o2;
          default: r = a & ~o2;
        endcase
        e.data = r; e.wr = 1'b1;
        if (cc) m_flags = {r[31], r == 32'h0, 2'b00};
      end
      4'd10: begin
        sh  = {m_flags[3] ^ m_flags[1], a[31:1]};
        ad  = m_y[0] ? o2 : 32'h0;
        r33 = {1'b0, sh} + {1'b0, ad};
        r   = r33[31:0];
        v   = (sh[31] == ad[31]) && (r[31] != sh[31]);
        m_flags = {r[31], r == 32'h0, v, r33[32]};
        m_y = {a[0], m_y[31:1]};
        e.data = r; e.wr = 1'b1;
      end
      4'd11: begin
        e.data = {fld, 10'b0}; e.wr = 1'b1;
      end
      4'd12: m_y = a ^ o2;
      default: ;
    endcase
    e.flags = m_flags;
    e.y     = m_y;
    last_res = e.data;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_set_cc = cc; in_field = fld;
    in_rs1 = a; in_rs2 = b;
    eq.push_back(e);
    tq.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: compares every result against the scoreboard head
  always begin
    @(negedge clk);
    #1;
    if (!rst && out_valid) begin
      checks++;
      if (eq.size() == 0) begin
        errors++;
        $display("FAIL R10: unexpected result data=%h, expected no result", out_data);
      end else begin
        exp_t  e;
        string t;
        e = eq.pop_front();
        t = tq.pop_front();
        if (out_data !== e.data || out_wr !== e.wr || out_trap !== e.trap ||
            out_flags !== e.flags || out_y !== e.y) begin
          errors++;
          $display("FAIL %s: got data=%h wr=%b trap=%b flags=%b y=%h, expected data=%h wr=%b trap=%b flags=%b y=%h",
                   t, out_data, out_wr, out_trap, out_flags, out_y,
                   e.data, e.wr, e.trap, e.flags, e.y);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_op = 4'd0; in_set_cc = 1'b0;
    in_field = '0; in_rs1 = '0; in_rs2 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    checks++; // R10 reset state
    if (out_valid !== 1'b0 || out_data !== 32'h0 || out_wr !== 1'b0 ||
        out_trap !== 1'b0 || out_flags !== 4'h0 || out_y !== 32'h0) begin
      errors++;
      $display("FAIL R10: reset state valid=%b data=%h flags=%b y=%h, expected all zero",
               out_valid, out_data, out_flags, out_y);
    end

    // R2 register and R1 immediate operands
    issue(4'd0, 1'b1, 22'h0, 32'd5, 32'd7, "R2");
    issue(4'd0, 1'b1, 22'h03FFF, 32'd10, 32'hDEAD, "R1");       // imm -1
    issue(4'd0, 1'b1, 22'h02FFF, 32'd1, 32'hDEAD, "R1");        // imm +4095
    issue(4'd0, 1'b1, 22'h03000, 32'd0, 32'h0, "R1");           // imm -4096
    issue(4'd0, 1'b1, 22'h0, 32'h7FFFFFFF, 32'd1, "R2");       // signed overflow
    issue(4'd1, 1'b1, 22'h0, 32'd3, 32'd5, "R2");              // borrow
    issue(4'd1, 1'b1, 22'h0, 32'h1234, 32'h1234, "R2");        // zero
    issue(4'd1, 1'b1, 22'h0, 32'h80000000, 32'd1, "R2");       // sub overflow
    // R3 logical
    issue(4'd2, 1'b1, 22'h0, 32'hF0F0F0F0, 32'hFF00FF00, "R3");
    issue(4'd3, 1'b1, 22'h0, 32'h0, 32'h0, "R3");
    issue(4'd4, 1'b1, 22'h0, 32'hA5A5A5A5, 32'hA5A5A5A5, "R3");
    issue(4'd5, 1'b1, 22'h0, 32'hFFFFFFFF, 32'h0000FFFF, "R3");
    // R4 no flag write
    issue(4'd1, 1'b1, 22'h0, 32'd3, 32'd5, "R4");
    issue(4'd0, 1'b0, 22'h0, 32'h7FFFFFFF, 32'd1, "R4");
    issue(4'd2, 1'b0, 22'h0, 32'h0, 32'h0, "R4");
    idle(2);
    // R5 tagged
    issue(4'd6, 1'b1, 22'h0, 32'd4, 32'd8, "R5");
    issue(4'd6, 1'b1, 22'h0, 32'd5, 32'd8, "R5");
    issue(4'd7, 1'b1, 22'h0, 32'd8, 32'd2, "R5");
    issue(4'd6, 1'b1, 22'h0, 32'h7FFFFFFC, 32'd4, "R5");
    // R6 trapping tagged
    issue(4'd1, 1'b1, 22'h0, 32'd1, 32'd1, "R6");
    issue(4'd8, 1'b1, 22'h0, 32'd5, 32'd8, "R6");
    issue(4'd9, 1'b1, 22'h02001, 32'd8, 32'd0, "R6");          // imm tag 1
    issue(4'd8, 1'b1, 22'h0, 32'd4, 32'd8, "R6");
    // R7 upper immediate
    issue(4'd11, 1'b1, 22'h3FFFFF, 32'h0, 32'h0, "R7");
    issue(4'd11, 1'b0, 22'h12345, 32'hFFFF, 32'h0, "R7");
    // R9 load Y, R8 multiply-step chain
    issue(4'd12, 1'b1, 22'h0, 32'h0000000B, 32'h0, "R9");
    issue(4'd1, 1'b1, 22'h0, 32'd3, 32'd5, "R8");              // N^V = 1
    issue(4'd10, 1'b0, 22'h0, 32'h0, 32'd3, "R8");
    for (int i = 0; i < 10; i++) issue(4'd10, 1'b0, 22'h0, last_res, 32'd3, "R8");
    issue(4'd12, 1'b0, 22'h02155, 32'hFFFF0000, 32'h0, "R9");
    for (int i = 0; i < 6; i++) issue(4'd10, 1'b1, 22'h02FF0, last_res, 32'h0, "R8");
    // R11 reserved codes
    issue(4'd13, 1'b1, 22'h0, 32'hFFFFFFFF, 32'h1, "R11");
    issue(4'd15, 1'b1, 22'h0, 32'h1, 32'h1, "R11");
    // Mixed traffic
    for (int i = 0; i < 80; i++) begin
      logic [3:0]  op;
      logic [31:0] a, b;
      logic [21:0] f;
      op = 4'($urandom_range(0, 15));
      a  = $urandom;
      b  = $urandom;
      f  = 22'($urandom);
      if ($urandom_range(0, 1) == 0) begin a[1:0] = 2'b00; b[1:0] = 2'b00; f[1:0] = 2'b00; end
      issue(op, 1'($urandom_range(0, 1)), f, a, b, tag_of(op));
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    idle(4);
    checks++; // R10 every request produced exactly one result
    if (eq.size() != 0) begin
      errors++;
      $display("FAIL R10: %0d results missing, expected 0", eq.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule